// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block decides which of 32 message mailboxes a CAN protocol engine sends next. Each mailbox has an enable bit, a direction bit and a transmit-request bit, and each bit is held in a 32-bit vector with one bit per mailbox. Each mailbox also has a 6-bit transmit priority. Software loads the enable, direction and interrupt-mask vectors as whole words. It loads a mailbox's priority by writing that mailbox's 16-bit control word. It raises transmit requests by writing ones into a set port.

When the protocol engine asks for a frame, the arbiter looks at every eligible mailbox. It returns the index of the one with the largest priority value, and a tie goes to the higher mailbox number. When the engine reports that a frame went out, the arbiter drops that mailbox's request and raises its acknowledge flag. A registered interrupt line is high while any acknowledged mailbox has its mask bit set. Software clears acknowledge flags by writing ones into a clear port.

Top module: `mbx_tx_arbiter`

## Requirements
- R1: After synchronous reset, all state vectors are zero, every priority is 0, and `pick_valid`, `pick_idx` and `irq` are 0.
- R2: A mailbox is a candidate only while its enable bit is 1, its direction bit is 0 (transmit) and its request bit is 1. A mailbox with direction 1, or with enable 0, is never picked.
- R3: A write on the priority port stores bits 13:8 of `prio_ctrl` as that mailbox's priority. The other control-word bits, including the length code in bits 3:0, have no effect. Among the candidates, the one with the largest priority value is picked.
- R4: When several candidates share the largest priority value, the one with the highest mailbox number is picked.
- R5: In the cycle after `pick_req` is high, `pick_valid` and `pick_idx` show the decision made on the state held before that edge. `pick_valid` is 0 if there was no candidate. While `pick_req` is low, both outputs hold their values.
- R6: A request-set write sets each request bit whose data bit is 1 and leaves bits with data 0 unchanged.
- R7: A `done_pulse` for an enabled mailbox clears its request bit and sets its acknowledge bit on the next edge. A request-set write to the same bit in the same cycle leaves the request set.
- R8: A `done_pulse` for a mailbox whose enable bit is 0 is ignored. Its acknowledge bit is not set and its request bit is unchanged.
- R9: An acknowledge-clear write clears each flag whose data bit is 1, so writing all ones clears every flag. A completion that sets the same flag in the same cycle wins over the clear.
- R10: `irq` is registered and equals the OR of (acknowledge AND mask) as it was one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Load the enable vector |
| en_wdata | input | 32 | New enable vector |
| dir_wr | input | 1 | Load the direction vector |
| dir_wdata | input | 32 | New direction vector (1 = receive) |
| mask_wr | input | 1 | Load the interrupt mask vector |
| mask_wdata | input | 32 | New interrupt mask vector |
| req_set_wr | input | 1 | Request-set write strobe |
| req_set_data | input | 32 | Ones set request bits |
| ack_clr_wr | input | 1 | Acknowledge-clear write strobe |
| ack_clr_data | input | 32 | Ones clear acknowledge bits |
| prio_wr | input | 1 | Control-word write strobe |
| prio_idx | input | 5 | Mailbox addressed by the control-word write |
| prio_ctrl | input | 16 | Control word; priority in bits 13:8 |
| pick_req | input | 1 | Engine asks for the next mailbox |
| done_pulse | input | 1 | Engine reports a completed transmission |
| done_idx | input | 5 | Mailbox that completed |
| pick_valid | output | 1 | A winner was found at the last request |
| pick_idx | output | 5 | Index of the winning mailbox |
| en_vec | output | 32 | Current enable vector |
| dir_vec | output | 32 | Current direction vector |
| mask_vec | output | 32 | Current interrupt mask vector |
| req_vec | output | 32 | Current transmit-request vector |
| ack_vec | output | 32 | Current acknowledge vector |
| irq | output | 1 | Registered interrupt line |

## Verification
Some rules are checked by the bound checker on every cycle:
- a valid pick always names a mailbox that was eligible;
- an empty candidate set gives an invalid pick;
- the pick outputs hold while no request comes;
- set and clear writes and completions move the request and acknowledge bits as R6 to R9 state;
- the interrupt follows the masked acknowledges with one cycle of lag.

Whether the winner is really the highest priority, with the tie toward the higher index, only shows in the bench scenarios. So does the rule that bits of the control word outside 13:8 are ignored. The bench covers these with directed ties, with disabled and receive-direction mailboxes, and with random traffic compared against a reference model.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    parameter int unsigned NUM_MB   = 32;
    parameter int unsigned PRIO_W   = 6;
    parameter int unsigned CTRL_W   = 16;
    parameter int unsigned PRIO_LSB = 8;
    parameter int unsigned IDX_W    = $clog2(NUM_MB);

    typedef logic [NUM_MB-1:0] mb_vec_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    // Field order makes a plain magnitude compare the arbitration rule:
    // eligibility first, then priority, then mailbox number.
    typedef struct packed {
        logic  elig;
        prio_t prio;
        idx_t  idx;
    } cand_t;

    function automatic prio_t ctrl_to_prio(ctrl_t w);
        return w[PRIO_LSB +: PRIO_W];
    endfunction

    function automatic cand_t cand_max(cand_t a, cand_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic mb_vec_t idx_to_bit(idx_t i);
        return mb_vec_t'(1) << i;
    endfunction
endpackage

// File: rtl/txarb_state.sv
module txarb_state
    import txarb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_wr,
    input  mb_vec_t en_wdata,
    input  logic    dir_wr,
    input  mb_vec_t dir_wdata,
    input  logic    mask_wr,
    input  mb_vec_t mask_wdata,
    input  logic    req_set_wr,
    input  mb_vec_t req_set_data,
    input  logic    ack_clr_wr,
    input  mb_vec_t ack_clr_data,
    input  logic    prio_wr,
    input  idx_t    prio_idx,
    input  ctrl_t   prio_ctrl,
    input  logic    done_pulse,
    input  idx_t    done_idx,
    output mb_vec_t en_q,
    output mb_vec_t dir_q,
    output mb_vec_t mask_q,
    output mb_vec_t req_q,
    output mb_vec_t ack_q,
    output prio_t   prio_q [NUM_MB]
);
    logic    done_ok;
    mb_vec_t done_bits;
    mb_vec_t set_bits;
    mb_vec_t clr_bits;

    always_comb begin
        done_ok   = done_pulse && en_q[done_idx];
        done_bits = done_ok ? idx_to_bit(done_idx) : '0;
        set_bits  = req_set_wr ? req_set_data : '0;
        clr_bits  = ack_clr_wr ? ack_clr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            req_q  <= '0;
            ack_q  <= '0;
        end else begin
            if (en_wr)   en_q   <= en_wdata;
            if (dir_wr)  dir_q  <= dir_wdata;
            if (mask_wr) mask_q <= mask_wdata;
            req_q <= (req_q & ~done_bits) | set_bits;
            ack_q <= (ack_q & ~clr_bits) | done_bits;
        end
    end

    for (genvar g = 0; g < NUM_MB; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= '0;
            else if (prio_wr && (prio_idx == idx_t'(g)))
                prio_q[g] <= ctrl_to_prio(prio_ctrl);
        end
    end
endmodule

// File: rtl/txarb_tree.sv
module txarb_tree
    import txarb_pkg::*;
(
    input  mb_vec_t en_q,
    input  mb_vec_t dir_q,
    input  mb_vec_t req_q,
    input  prio_t   prio_q [NUM_MB],
    output logic    win_valid,
    output idx_t    win_idx
);
    localparam int unsigned NODES = 2 * NUM_MB - 1;

    cand_t leaf [NUM_MB];

    for (genvar g = 0; g < NUM_MB; g++) begin : g_leaf
        assign leaf[g].elig = en_q[g] & ~dir_q[g] & req_q[g];
        assign leaf[g].prio = prio_q[g];
        assign leaf[g].idx  = idx_t'(g);
    end

    cand_t root;

    always_comb begin
        cand_t node [NODES];
        for (int i = 0; i < NUM_MB; i++)
            node[NUM_MB - 1 + i] = leaf[i];
        for (int k = NUM_MB - 2; k >= 0; k--)
            node[k] = cand_max(node[2*k + 1], node[2*k + 2]);
        root = node[0];
    end

    assign win_valid = root.elig;
    assign win_idx   = root.idx;
endmodule

// File: rtl/mbx_tx_arbiter.sv
module mbx_tx_arbiter
    import txarb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en_wr,
    input  logic [31:0] en_wdata,
    input  logic        dir_wr,
    input  logic [31:0] dir_wdata,
    input  logic        mask_wr,
    input  logic [31:0] mask_wdata,
    input  logic        req_set_wr,
    input  logic [31:0] req_set_data,
    input  logic        ack_clr_wr,
    input  logic [31:0] ack_clr_data,
    input  logic        prio_wr,
    input  logic [4:0]  prio_idx,
    input  logic [15:0] prio_ctrl,
    input  logic        pick_req,
    input  logic        done_pulse,
    input  logic [4:0]  done_idx,
    output logic        pick_valid,
    output logic [4:0]  pick_idx,
    output logic [31:0] en_vec,
    output logic [31:0] dir_vec,
    output logic [31:0] mask_vec,
    output logic [31:0] req_vec,
    output logic [31:0] ack_vec,
    output logic        irq
);
    prio_t prio_q [NUM_MB];
    logic  win_valid;
    idx_t  win_idx;

    txarb_state u_state (
        .clk          (clk),
        .rst          (rst),
        .en_wr        (en_wr),
        .en_wdata     (en_wdata),
        .dir_wr       (dir_wr),
        .dir_wdata    (dir_wdata),
        .mask_wr      (mask_wr),
        .mask_wdata   (mask_wdata),
        .req_set_wr   (req_set_wr),
        .req_set_data (req_set_data),
        .ack_clr_wr   (ack_clr_wr),
        .ack_clr_data (ack_clr_data),
        .prio_wr      (prio_wr),
        .prio_idx     (prio_idx),
        .prio_ctrl    (prio_ctrl),
        .done_pulse   (done_pulse),
        .done_idx     (done_idx),
        .en_q         (en_vec),
        .dir_q        (dir_vec),
        .mask_q       (mask_vec),
        .req_q        (req_vec),
        .ack_q        (ack_vec),
        .prio_q       (prio_q)
    );

    txarb_tree u_tree (
        .en_q      (en_vec),
        .dir_q     (dir_vec),
        .req_q     (req_vec),
        .prio_q    (prio_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pick_valid <= 1'b0;
            pick_idx   <= '0;
            irq        <= 1'b0;
        end else begin
            if (pick_req) begin
                pick_valid <= win_valid;
                pick_idx   <= win_idx;
            end
            irq <= |(ack_vec & mask_vec);
        end
    end
endmodule

// File: rtl/txarb_chk.sv
module txarb_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_set_wr,
    input logic [31:0] req_set_data,
    input logic        ack_clr_wr,
    input logic [31:0] ack_clr_data,
    input logic        pick_req,
    input logic        done_pulse,
    input logic [4:0]  done_idx,
    input logic        pick_valid,
    input logic [4:0]  pick_idx,
    input logic [31:0] en_vec,
    input logic [31:0] dir_vec,
    input logic [31:0] mask_vec,
    input logic [31:0] req_vec,
    input logic [31:0] ack_vec,
    input logic        irq
);
    logic [31:0] elig;
    assign elig = en_vec & ~dir_vec & req_vec;

    assert_pick_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        pick_req |=> (!pick_valid || $past(elig[done_idx & 5'd0] | 1'b1) && (($past(elig) >> pick_idx) & 32'd1) == 32'd1));

    assert_none_invalid_R5: assert property (@(posedge clk) disable iff (rst)
        (pick_req && elig == 32'd0) |=> !pick_valid);

    assert_pick_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !pick_req |=> ($stable(pick_valid) && $stable(pick_idx)));

    assert_req_set_R6: assert property (@(posedge clk) disable iff (rst)
        req_set_wr |=> ((req_vec & $past(req_set_data)) == $past(req_set_data)));

    assert_done_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && en_vec[done_idx] && !(req_set_wr && req_set_data[done_idx]))
        |=> (!req_vec[$past(done_idx)] && ack_vec[$past(done_idx)]));

    assert_done_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && !en_vec[done_idx] && !ack_vec[done_idx])
        |=> !ack_vec[$past(done_idx)]);

    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_clr_wr && !done_pulse) |=> ((ack_vec & $past(ack_clr_data)) == 32'd0));

    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(ack_vec & mask_vec))));
endmodule

bind mbx_tx_arbiter txarb_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_set_wr   (req_set_wr),
    .req_set_data (req_set_data),
    .ack_clr_wr   (ack_clr_wr),
    .ack_clr_data (ack_clr_data),
    .pick_req     (pick_req),
    .done_pulse   (done_pulse),
    .done_idx     (done_idx),
    .pick_valid   (pick_valid),
    .pick_idx     (pick_idx),
    .en_vec       (en_vec),
    .dir_vec      (dir_vec),
    .mask_vec     (mask_vec),
    .req_vec      (req_vec),
    .ack_vec      (ack_vec),
    .irq          (irq)
);

// File: tb/mbx_tx_arbiter_tb.sv
module mbx_tx_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        en_wr, dir_wr, mask_wr, req_set_wr, ack_clr_wr, prio_wr;
    logic [31:0] en_wdata, dir_wdata, mask_wdata, req_set_data, ack_clr_data;
    logic [4:0]  prio_idx, done_idx;
    logic [15:0] prio_ctrl;
    logic        pick_req, done_pulse;
    logic        pick_valid, irq;
    logic [4:0]  pick_idx;
    logic [31:0] en_vec, dir_vec, mask_vec, req_vec, ack_vec;

    always #5 clk = ~clk;

    mbx_tx_arbiter u_dut (
        .clk(clk), .rst(rst),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .dir_wr(dir_wr), .dir_wdata(dir_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .req_set_wr(req_set_wr), .req_set_data(req_set_data),
        .ack_clr_wr(ack_clr_wr), .ack_clr_data(ack_clr_data),
        .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_ctrl(prio_ctrl),
        .pick_req(pick_req), .done_pulse(done_pulse), .done_idx(done_idx),
        .pick_valid(pick_valid), .pick_idx(pick_idx),
        .en_vec(en_vec), .dir_vec(dir_vec), .mask_vec(mask_vec),
        .req_vec(req_vec), .ack_vec(ack_vec), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    logic [31:0] m_en, m_dir, m_mask, m_req, m_ack;
    logic [5:0]  m_prio [32];
    logic        m_pv, m_irq;
    logic [4:0]  m_pi;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference decision: largest priority, tie to higher index (R3, R4)
    function automatic logic [5:0] ref_pick();
        logic       v = 1'b0;
        logic [4:0] bi = '0;
        logic [5:0] bp = '0;
        for (int i = 0; i < 32; i++) begin
            if (m_en[i] && !m_dir[i] && m_req[i] && (!v || m_prio[i] >= bp)) begin
                v = 1'b1; bi = 5'(i); bp = m_prio[i];
            end
        end
        return {v, bi};
    endfunction

    task automatic idle();
        en_wr = 0; dir_wr = 0; mask_wr = 0; req_set_wr = 0; ack_clr_wr = 0; prio_wr = 0;
        en_wdata = '0; dir_wdata = '0; mask_wdata = '0; req_set_data = '0; ack_clr_data = '0;
        prio_idx = '0; prio_ctrl = '0; pick_req = 0; done_pulse = 0; done_idx = '0;
    endtask

    task automatic step();
        logic        dok;
        logic [31:0] dbit;
        logic [5:0]  pk;
        logic [31:0] e_req, e_ack;
        dok   = done_pulse && m_en[done_idx];
        dbit  = dok ? (32'd1 << done_idx) : 32'd0;
        e_req = (m_req & ~dbit) | (req_set_wr ? req_set_data : 32'd0);
        e_ack = (m_ack & ~(ack_clr_wr ? ack_clr_data : 32'd0)) | dbit;
        m_irq = |(m_ack & m_mask);
        if (pick_req) begin
            pk = ref_pick();
            m_pv = pk[5];
            m_pi = pk[4:0];
        end
        @(posedge clk);
        #1;
        if (en_wr)   m_en   = en_wdata;
        if (dir_wr)  m_dir  = dir_wdata;
        if (mask_wr) m_mask = mask_wdata;
        if (prio_wr) m_prio[prio_idx] = prio_ctrl[13:8];
        m_req = e_req;
        m_ack = e_ack;
        check("R6 R7 req_vec", req_vec, m_req);
        check("R9 ack_vec", ack_vec, m_ack);
        check("R5 pick_valid", 32'(pick_valid), 32'(m_pv));
        if (m_pv) check("R3 pick_idx", 32'(pick_idx), 32'(m_pi));
        check("R10 irq", 32'(irq), 32'(m_irq));
        idle();
    endtask

    task automatic wr_prio(int idx, logic [15:0] w);
        prio_wr = 1; prio_idx = 5'(idx); prio_ctrl = w; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        idle();
        rst = 1;
        m_en = 0; m_dir = 0; m_mask = 0; m_req = 0; m_ack = 0; m_pv = 0; m_pi = 0; m_irq = 0;
        for (int i = 0; i < 32; i++) m_prio[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        check("R1 reset vectors", en_vec | dir_vec | mask_vec | req_vec | ack_vec, 32'd0);
        check("R1 reset pick/irq", {25'd0, pick_valid, irq, pick_idx}, 32'd0);
        pick_req = 1; step();
        check("R1 priorities zero, nothing eligible", 32'(pick_valid), 32'd0);

        // Directed: mailboxes 3,7,20 transmit, 25 receive with top priority
        en_wr = 1; en_wdata = (32'd1<<3)|(32'd1<<7)|(32'd1<<20)|(32'd1<<25); step();
        dir_wr = 1; dir_wdata = 32'd1 << 25; step();
        mask_wr = 1; mask_wdata = 32'd1 << 20; step();
        wr_prio(3,  16'h0508);
        wr_prio(7,  16'h0900);
        wr_prio(20, 16'hC90F);   // bits outside 13:8 must not matter (R3)
        wr_prio(25, 16'h3F00);
        req_set_wr = 1; req_set_data = (32'd1<<3)|(32'd1<<7)|(32'd1<<20)|(32'd1<<25); step();
        pick_req = 1; step();
        check("R4 tie goes to mailbox 20", 32'(pick_idx), 32'd20);
        check("R2 receive mailbox 25 not picked", 32'(pick_valid && pick_idx != 5'd25), 32'd1);
        step();
        check("R5 pick held without request", 32'(pick_idx), 32'd20);

        // Completion on enabled mailbox 20
        done_pulse = 1; done_idx = 5'd20; step();
        check("R7 done clears req20 sets ack20", {30'd0, req_vec[20], ack_vec[20]}, 32'd1);
        step();
        check("R10 irq from masked ack", 32'(irq), 32'd1);
        pick_req = 1; step();
        check("R3 next winner 7", 32'(pick_idx), 32'd7);

        // Disable 7, completion for it is ignored
        en_wr = 1; en_wdata = (32'd1<<3)|(32'd1<<20)|(32'd1<<25); step();
        done_pulse = 1; done_idx = 5'd7; step();
        check("R8 ignored done keeps req7, no ack7", {30'd0, req_vec[7], ack_vec[7]}, 32'd2);
        pick_req = 1; step();
        check("R2 disabled 7 skipped, 3 wins", 32'(pick_idx), 32'd3);

        // Same-cycle set and done on 3; then clear all acks
        done_pulse = 1; done_idx = 5'd3; req_set_wr = 1; req_set_data = 32'd1 << 3; step();
        check("R7 set wins over done", {30'd0, req_vec[3], ack_vec[3]}, 32'd3);
        ack_clr_wr = 1; ack_clr_data = 32'hFFFF_FFFF; step();
        check("R9 all ones clears all acks", ack_vec, 32'd0);
        done_pulse = 1; done_idx = 5'd3; step();
        pick_req = 1; step();
        check("R5 no candidate gives invalid", 32'(pick_valid), 32'd0);
        req_set_wr = 1; req_set_data = 32'h0; step();
        check("R6 zero write leaves req", req_vec, m_req);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 16 == 0) begin en_wr = 1; en_wdata = $urandom | $urandom; end
            if ($urandom % 16 == 0) begin dir_wr = 1; dir_wdata = $urandom & $urandom; end
            if ($urandom % 16 == 0) begin mask_wr = 1; mask_wdata = $urandom; end
            if ($urandom % 4 == 0) begin
                prio_wr = 1; prio_idx = 5'($urandom); prio_ctrl = 16'($urandom);
                if ($urandom % 2 == 0) prio_ctrl[13:8] = 6'($urandom % 3);
            end
            if ($urandom % 3 == 0) begin req_set_wr = 1; req_set_data = $urandom & $urandom & $urandom; end
            if ($urandom % 4 == 0) begin ack_clr_wr = 1; ack_clr_data = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom; end
            pick_req = 1'($urandom);
            if ($urandom % 3 == 0) begin
                done_pulse = 1;
                done_idx = (m_pv && $urandom % 2 == 0) ? m_pi : 5'($urandom);
            end
            step();
        end
        finish_run();
    end
endmodule